// File: doc/BRIEF.md
# Multi-Channel DMA Request Arbiter

This block decides which of eight DMA channels drives the transfer engine. Each channel may be asked for service by a hardware request line or by a one-cycle software pulse. A software pulse is remembered until the channel is granted. Requests from disabled channels never win.

When the engine is idle, the arbiter selects a winner in two steps. First, channels with their boost bit set are preferred over all others. Second, within the chosen group, the lowest channel number wins. The winner keeps the grant for a burst of 2^R acknowledged transfers, where R is that channel's own exponent. The grant ends earlier if the engine marks a transfer as the last one of the channel's cycle. In that case the channel's done flag pulses. Arbitration happens again only after the grant has ended.

The block also shows pending requests, including those of disabled channels. It also drives a bus-priority output, which tells the interconnect whether DMA or CPU accesses win.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset, `grant_vld` is 0, `done` is all zero and `req_status` is all zero until a request arrives.
- R2: If any enabled requester has its `hi_prio` bit set, the grant goes to such a boosted channel, even when unboosted channels with lower numbers are also requesting.
- R3: Among enabled requesters at the same priority level, the lowest channel number is granted. The granted channel appears on `grant_id`, and `grant_vld` rises on the clock edge after the request is seen while idle.
- R4: A granted channel with exponent R (field `r_val[ch*4 +: 4]`) keeps the grant through 2^R acknowledged transfers. `grant_vld` is low in the cycle after the 2^R-th acknowledge, and is not lower before then.
- R5: An acknowledge with `xfer_last` high ends the grant at once. It also pulses `done[grant_id]` high for exactly one cycle, in the cycle after that acknowledge.
- R6: A one-cycle `sw_req[ch]` pulse is held pending and shown on `req_status[ch]` until the channel is granted. It is cleared in the cycle in which the grant appears.
- R7: `req_status[ch]` reflects `hw_req[ch]` whatever the state of `chan_en[ch]`. A channel whose enable bit is 0 is never granted.
- R8: `grant_id` stays constant while `grant_vld` is high. A higher-priority request that arrives during a burst does not preempt the burst.
- R9: `dma_bus_pri` depends on `bus_mode` as follows:
  - 0: `dma_bus_pri` is 0 (CPU wins).
  - 1: `dma_bus_pri` is 1 (DMA wins).
  - 2: `dma_bus_pri` equals `cpu_sleep`.
  - 3: `dma_bus_pri` is 0.
- R10: `xfer_ack` and `xfer_last` are ignored while no grant is active. They pulse no `done` bit and disturb no later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 8 | Hardware request level per channel |
| sw_req | input | 8 | Software request pulse per channel |
| chan_en | input | 8 | Channel enable |
| hi_prio | input | 8 | Per-channel priority boost |
| r_val | input | 32 | Burst exponent per channel, 4 bits each |
| bus_mode | input | 2 | Bus sharing policy |
| cpu_sleep | input | 1 | CPU is in a sleep state |
| xfer_ack | input | 1 | Engine completed one transfer for the granted channel |
| xfer_last | input | 1 | That transfer ends the channel's cycle |
| grant_vld | output | 1 | A channel holds the grant |
| grant_id | output | 3 | Granted channel number |
| req_status | output | 8 | Pending requests, enabled or not |
| done | output | 8 | One-cycle completion pulse per channel |
| dma_bus_pri | output | 1 | DMA has bus priority over the CPU |

## Verification
The hardest situation to create from the ports is a priority conflict that lands in the middle of a burst. In that case a boosted or lower-numbered channel must wait rather than preempt the channel that holds the grant. To reach it, the stimulus first waits for a grant to appear. It then raises the competing request between acknowledges, and checks `grant_id` after every transfer. A second hard case is a software pulse parked on a disabled channel. The bench leaves the pulse pending for several cycles and only then enables the channel, so that the latch and its clearing on grant are both visible on `req_status`.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter  int NCH = 8,
  parameter  int RW  = 4,
  localparam int IDW = $clog2(NCH),
  localparam int CW  = (1 << RW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    sw_req,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    hi_prio,
  input  logic [NCH*RW-1:0] r_val,
  input  logic [1:0]        bus_mode,
  input  logic              cpu_sleep,
  input  logic              xfer_ack,
  input  logic              xfer_last,
  output logic              grant_vld,
  output logic [IDW-1:0]    grant_id,
  output logic [NCH-1:0]    req_status,
  output logic [NCH-1:0]    done,
  output logic              dma_bus_pri
);

  logic [NCH-1:0] sw_pend, eff, boosted, pick_set, win_oh;
  logic [IDW-1:0] win_id;
  logic [CW-1:0]  cnt;
  logic [RW-1:0]  cur_r;
  logic           launch, burst_end, fin;

  assign eff        = (hw_req | sw_pend) & chan_en;
  assign boosted    = eff & hi_prio;
  assign pick_set   = (|boosted) ? boosted : eff;
  assign req_status = hw_req | sw_pend;

  always_comb begin
    win_id = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pick_set[i]) win_id = IDW'(i);
  end

  assign launch    = !grant_vld && (|eff);
  assign win_oh    = NCH'(launch) << win_id;
  assign cur_r     = r_val[grant_id*RW +: RW];
  assign burst_end = (cnt == ((CW'(1) << cur_r) - CW'(1)));
  assign fin       = grant_vld && xfer_ack && (xfer_last || burst_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend   <= '0;
      done      <= '0;
      grant_vld <= 1'b0;
      grant_id  <= '0;
      cnt       <= '0;
    end else begin
      sw_pend <= (sw_pend & ~win_oh) | sw_req;
      done    <= (grant_vld && xfer_ack && xfer_last) ? (NCH'(1) << grant_id) : '0;
      if (launch) begin
        grant_vld <= 1'b1;
        grant_id  <= win_id;
        cnt       <= '0;
      end else if (fin) begin
        grant_vld <= 1'b0;
      end else if (grant_vld && xfer_ack) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    case (bus_mode)
      2'd1:    dma_bus_pri = 1'b1;
      2'd2:    dma_bus_pri = cpu_sleep;
      default: dma_bus_pri = 1'b0;
    endcase
  end

endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter  int NCH = 8,
  localparam int IDW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] hw_req,
  input logic [NCH-1:0] chan_en,
  input logic [NCH-1:0] hi_prio,
  input logic           xfer_ack,
  input logic           xfer_last,
  input logic           grant_vld,
  input logic [IDW-1:0] grant_id,
  input logic [NCH-1:0] done
);

  logic [NCH-1:0] gmask;
  assign gmask = NCH'(1) << grant_id;

  p_hold_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && $past(grant_vld) |-> grant_id == $past(grant_id));

  p_enabled_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) |-> |($past(chan_en) & gmask));

  p_boost_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_vld) && (|$past(hw_req & chan_en & hi_prio)) |-> |($past(hi_prio) & gmask));

  p_last_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld && xfer_ack && xfer_last |=> !grant_vld);

  p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|done) |-> $past(grant_vld && xfer_ack && xfer_last));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .chan_en(chan_en),
  .hi_prio(hi_prio), .xfer_ack(xfer_ack), .xfer_last(xfer_last),
  .grant_vld(grant_vld), .grant_id(grant_id), .done(done));

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
  logic       clk = 0, rst_n = 0;
  logic [7:0] hw_req = 0, sw_req = 0, chan_en = 0, hi_prio = 0;
  logic [31:0] r_val = 0;
  logic [1:0] bus_mode = 0;
  logic       cpu_sleep = 0, xfer_ack = 0, xfer_last = 0;
  logic       grant_vld, dma_bus_pri;
  logic [2:0] grant_id;
  logic [7:0] req_status, done;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  logic prev_gv = 0;
  bit finished = 0;

  dma_chan_arbiter i_dma_chan_arbiter (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: each new grant is compared with the next expected channel
  always @(negedge clk) begin
    if (rst_n && grant_vld && !prev_gv) begin
      if (exp_q.size() == 0) chk("R3 unexpected grant", grant_id, -1);
      else chk("R2/R3 grant order", grant_id, exp_q.pop_front());
    end
    prev_gv = grant_vld;
  end

  task automatic set_r(int ch, int v);
    r_val[ch*4 +: 4] = 4'(v);
  endtask

  // driver: expect channel id, serve n acks, optionally flag last on final one
  task automatic serve(int id, int n, bit last, logic [7:0] raise);
    int w = 0;
    exp_q.push_back(id);
    while (!grant_vld && w < 20) begin @(negedge clk); w++; end
    if (!grant_vld) begin chk("R3 grant timeout", 0, 1); return; end
    hw_req[id] = 1'b0;
    hw_req = hw_req | raise;
    for (int i = 0; i < n; i++) begin
      xfer_ack = 1; xfer_last = last && (i == n - 1);
      @(negedge clk);
      chk("R8 grant_id stable", grant_id, id);
      if (i < n - 1) chk("R4 grant held", grant_vld, 1);
    end
    xfer_ack = 0; xfer_last = 0;
    chk("R4/R5 released", grant_vld, 0);
    chk("R5 done pulse", done, last ? (1 << id) : 0);
    @(negedge clk);
    chk("R5 done one cycle", done[id], 0);
  endtask

  initial begin
    #1000000;
    chk("watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 grant_vld", grant_vld, 0);
    chk("R1 done", done, 0);
    chk("R1 req_status", req_status, 0);

    // R9 bus policy
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 2; s++) begin
        bus_mode = 2'(m); cpu_sleep = s[0];
        #1;
        chk("R9 dma_bus_pri", dma_bus_pri, (m == 1) || (m == 2 && s == 1));
      end

    // R7 disabled channel shows request but is never granted
    hw_req[2] = 1;
    repeat (4) @(negedge clk);
    chk("R7 status of disabled", req_status[2], 1);
    chk("R7 disabled not granted", grant_vld, 0);
    hw_req[2] = 0;

    // R3 lowest number first, R=0 bursts of one
    chan_en = 8'hFF;
    hw_req = 8'b0010_1000;
    serve(3, 1, 0, 0);
    serve(5, 1, 0, 0);

    // R2 boost beats lower number
    hi_prio[6] = 1;
    hw_req = 8'b0100_0010;
    serve(6, 1, 1, 0);
    serve(1, 1, 0, 0);
    hi_prio = 0;

    // R4 and R8: 4-transfer burst, boosted lower channel arrives mid-burst
    set_r(5, 2);
    hw_req[5] = 1;
    hi_prio[0] = 1;
    serve(5, 4, 0, 8'b0000_0001);
    serve(0, 1, 0, 0);
    hi_prio = 0;

    // R5 early completion on a long burst
    set_r(1, 3);
    hw_req[1] = 1;
    serve(1, 3, 1, 0);

    // R6 software pulse held pending on a disabled channel
    chan_en[4] = 0;
    sw_req[4] = 1;
    @(negedge clk);
    sw_req[4] = 0;
    repeat (3) @(negedge clk);
    chk("R6 sw pending shown", req_status[4], 1);
    chk("R6 no grant while disabled", grant_vld, 0);
    chan_en[4] = 1;
    serve(4, 1, 0, 0);
    chk("R6 sw pending cleared", req_status[4], 0);

    // R10 acks while idle are ignored
    xfer_ack = 1; xfer_last = 1;
    repeat (3) @(negedge clk);
    xfer_ack = 0; xfer_last = 0;
    chk("R10 no done when idle", done, 0);
    chk("R10 no grant when idle", grant_vld, 0);
    set_r(7, 1);
    hw_req[7] = 1;
    serve(7, 2, 0, 0);

    repeat (3) @(negedge clk);
    chk("R3 no stray grants", exp_q.size(), 0);
    summary();
  end
endmodule